// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block is the address-recognition front end of an I2C target. It watches the SCL and SDA lines, finds START and STOP conditions, and shifts in the address byte or bytes. It compares what it receives with a programmed own address. A per-bit mask decides which bits take part in the comparison. When the address matches, the block pulls SDA low for the acknowledge clock. One address and mask pair can therefore answer a whole family of bus addresses.

Both addressing forms are supported. In 7-bit mode one byte is compared. In 10-bit mode a fixed-prefix header byte carries the two upper address bits, which are always compared exactly, and a second byte carries the low eight bits, which are compared through the mask. A small write-only configuration port loads the own address, the mask and a 4-bit mode code. The mode code also decides whether a write to the address location lands in the address register or in the mask register. The configuration port accepts a write on every clock cycle and never applies back-pressure.

After a complete match the block gives a one-cycle match strobe and reports the read/write bit. Data bytes that follow the address are not handled here.

Top module: `i2c_mask_addr_slave`

## Requirements
- R1: After reset, `sda_oe`, `match_strobe` and `rnw` are all 0, the mode code is 0000 (no slave mode), and the own address is zero.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP in the middle of an address byte returns the matcher to idle without an acknowledge. A repeated START in the middle of an address byte restarts address reception from its first bit.
- R3: For each mask bit, a 0 makes that address bit a don't-care and a 1 requires the received bit to equal the own-address bit.
- R4: The mask register resets to all ones, so matching is exact until a mask is written.
- R5: The configuration port has three locations. With `cfg_sel`=0, a write goes to the mask when the mode code is 1001 and to the low own-address byte otherwise. With `cfg_sel`=1, `cfg_wdata[1:0]` is written to the two upper own-address bits. With `cfg_sel`=2, `cfg_wdata[3:0]` is written to the mode code. Mode 0110 selects 7-bit slave, 0111 selects 10-bit slave, and every other code gives no acknowledge.
- R6: In 7-bit mode, received byte bits [7:1] are compared with own-address bits [7:1] under mask bits [7:1], and received bit 0 is R/W. With own address A0h and mask F3h, the bytes A0h, A4h, A8h and ACh are acknowledged (and A5h as a read), while A2h, A6h, B0h and E0h are not.
- R7: In 10-bit mode, the first byte must be 11110 followed by the two upper own-address bits and then R/W, compared exactly. Once that byte has been acknowledged, the second byte's eight bits are compared with the low own-address byte under the full 8-bit mask.
- R8: The acknowledge drives `sda_oe` high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit. `sda_oe` is low during the eighth bit's high phase and after the ninth clock.
- R9: `match_strobe` is high for exactly one cycle when the acknowledge of the final address byte starts: the only byte in 7-bit mode, the second byte in 10-bit mode. `rnw` is updated at the same moment to the R/W bit of the first byte.
- R10: A mismatch on any unmasked bit leaves SDA released in the ninth clock. After that, the block ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration location: 0 address/mask, 1 upper address bits, 2 mode |
| cfg_wdata | input | 8 | Configuration write data |
| match_strobe | output | 1 | One-cycle pulse on a complete address match |
| rnw | output | 1 | R/W bit of the last matched transfer (1 = read) |

## Verification
The bench targets the corner cases of the mask. Bit 1 is compared while bits 2 and 3 are free, so a design that inverts the mask polarity would acknowledge A2h and refuse A4h. It also checks that a design treating R/W as an address bit would refuse A5h. Shared-location routing is checked by writing the address under a slave mode and the mask under 1001. A design that ignores the mode code would overwrite the wrong register and then acknowledge the wrong addresses. In 10-bit mode the bench sends a wrong upper pair and a wrong second byte, so a design that masks the header or strobes after the first byte shows up in the strobe count. Aborted bytes (STOP and repeated START after four bits) and a byte clocked in after a mismatch without a new START catch a matcher that keeps stale bit counts or re-arms by itself.

// File: rtl/i2c_mam_pkg.sv
package i2c_mam_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 2;

  localparam logic [3:0] MODE_MASK_ACC = 4'b1001;
  localparam logic [3:0] MODE_SLV7     = 4'b0110;
  localparam logic [3:0] MODE_SLV10    = 4'b0111;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_MODE    = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_DONE,
    ST_IGNORE
  } mstate_e;
endpackage

// File: rtl/i2c_mam_bus_sync.sv
module i2c_mam_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_q,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
      for (int i = STAGES - 1; i > 0; i--) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  // both conditions need SCL high on both sides of the SDA edge
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_mam_cfg.sv
module i2c_mam_cfg
  import i2c_mam_pkg::*;
#(
  parameter int AW = BYTE_W,
  parameter int HW = HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] own_lo,
  output logic [HW-1:0] own_hi,
  output logic [AW-1:0] mask,
  output logic [3:0]    mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_lo <= '0;
      own_hi <= '0;
      mask   <= '1;
      mode   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_ADDR_LO: begin
          if (mode == MODE_MASK_ACC) mask <= cfg_wdata;
          else                       own_lo <= cfg_wdata;
        end
        SEL_ADDR_HI: own_hi <= cfg_wdata[HW-1:0];
        SEL_MODE:    mode   <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mam_compare.sv
module i2c_mam_compare #(
  parameter int AW = 8,
  parameter int HW = 2
) (
  input  logic [AW-1:0] rx_byte,
  input  logic [AW-1:0] own_lo,
  input  logic [HW-1:0] own_hi,
  input  logic [AW-1:0] mask,
  input  logic          ten_bit,
  input  logic          second,
  output logic          hit
);
  localparam int PRE_W = AW - HW - 1;
  localparam logic [PRE_W-1:0] TEN_PREFIX = {{(PRE_W-1){1'b1}}, 1'b0};

  logic [AW-1:0] bit_ok;

  genvar g;
  generate
    for (g = 0; g < AW; g++) begin : g_bit
      assign bit_ok[g] = ~mask[g] | (rx_byte[g] == own_lo[g]);
    end
  endgenerate

  logic hit7, hit_hdr, hit_lo;
  assign hit7    = &bit_ok[AW-1:1];
  assign hit_lo  = &bit_ok;
  assign hit_hdr = (rx_byte[AW-1:HW+1] == TEN_PREFIX) && (rx_byte[HW:1] == own_hi);

  always_comb begin
    if (!ten_bit)    hit = hit7;
    else if (second) hit = hit_lo;
    else             hit = hit_hdr;
  end
endmodule

// File: rtl/i2c_mask_addr_slave.sv
module i2c_mask_addr_slave
  import i2c_mam_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic              match_strobe,
  output logic              rnw
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] own_lo, mask_q;
  logic [HI_W-1:0]   own_hi;
  logic [3:0]        mode;

  i2c_mam_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_q(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_mam_cfg #(.AW(BYTE_W), .HW(HI_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .own_lo(own_lo), .own_hi(own_hi),
    .mask(mask_q), .mode(mode)
  );

  logic slave_on, ten_bit;
  assign ten_bit  = (mode == MODE_SLV10);
  assign slave_on = (mode == MODE_SLV7) || ten_bit;

  mstate_e           state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              second_q;
  logic              hdr_rw;
  logic              hit;
  logic              final_byte;

  i2c_mam_compare #(.AW(BYTE_W), .HW(HI_W)) u_cmp (
    .rx_byte(shreg), .own_lo(own_lo), .own_hi(own_hi), .mask(mask_q),
    .ten_bit(ten_bit), .second(second_q), .hit(hit)
  );

  assign final_byte = !ten_bit || second_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      second_q     <= 1'b0;
      hdr_rw       <= 1'b0;
      sda_oe       <= 1'b0;
      match_strobe <= 1'b0;
      rnw          <= 1'b0;
    end else if (!slave_on) begin
      state        <= ST_IDLE;
      sda_oe       <= 1'b0;
      match_strobe <= 1'b0;
    end else begin
      match_strobe <= 1'b0;
      if (start_det) begin
        state    <= ST_SHIFT;
        bit_cnt  <= '0;
        second_q <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (hit) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (!second_q) hdr_rw <= shreg[0];
                if (final_byte) begin
                  match_strobe <= 1'b1;
                  rnw          <= second_q ? hdr_rw : shreg[0];
                end
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              if (ten_bit && !second_q) begin
                second_q <= 1'b1;
                state    <= ST_SHIFT;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mam_checker.sv
module i2c_mam_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic stop_det,
  input logic slave_on,
  input logic sda_oe,
  input logic match_strobe
);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_strobe |=> !match_strobe)
    else $error("match strobe longer than one cycle");

  assert_strobe_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_strobe |-> sda_oe)
    else $error("match strobe without acknowledge drive");

  assert_ack_starts_low_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s))
    else $error("acknowledge drive began outside SCL low");

  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe)
    else $error("SDA still driven after STOP");

  assert_idle_mode_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_on |=> !sda_oe)
    else $error("SDA driven outside slave modes");
endmodule

bind i2c_mask_addr_slave i2c_mam_checker u_checker (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .slave_on(slave_on), .sda_oe(sda_oe), .match_strobe(match_strobe)
);

// File: tb/test_i2c_mask_addr_slave.sv
module test_i2c_mask_addr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 10;
  localparam int SETTLE     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       sda_oe, match_strobe, rnw;
  logic       sda_line;

  int n_chk = 0;
  int n_err = 0;
  int strobes = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && match_strobe) strobes++;

  i2c_mask_addr_slave i_i2c_mask_addr_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .match_strobe(match_strobe), .rnw(rnw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_c(HALF);
    scl = 1'b1;   wait_c(HALF);
    sda_m = 1'b0; wait_c(HALF);
    scl = 1'b0;   wait_c(SETTLE);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_c(HALF);
    scl = 1'b1;   wait_c(HALF);
    sda_m = 1'b1; wait_c(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic hi_oe);
    hi_oe = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_c(HALF);
      scl = 1'b1;   wait_c(HALF/2);
      hi_oe = sda_oe;
      wait_c(HALF/2);
      scl = 1'b0;   wait_c(SETTLE);
    end
  endtask

  // full byte plus ninth clock; checks acknowledge and its window
  task automatic do_byte(input string req, input logic [7:0] b, input logic exp_ack);
    logic pre, ack, post;
    send_bits(b, 8, pre);
    sda_m = 1'b1; wait_c(HALF);
    scl = 1'b1;   wait_c(HALF/2);
    ack = sda_oe;
    wait_c(HALF/2);
    scl = 1'b0;   wait_c(HALF);
    post = sda_oe;
    chk(req, {31'd0, ack}, {31'd0, exp_ack});
    chk("R8 oe low in bit 8", {31'd0, pre}, 32'd0);
    chk("R8 oe low after bit 9", {31'd0, post}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 match_strobe", {31'd0, match_strobe}, 32'd0);
    chk("R1 rnw", {31'd0, rnw}, 32'd0);
    bus_start();
    do_byte("R1 no ack in reset mode", 8'h00, 1'b0);
    bus_stop();
  endtask

  task automatic t_default_exact();
    int s0;
    cfg_write(2'd2, 8'h06);
    cfg_write(2'd0, 8'hA0);
    bus_start(); do_byte("R4 exact default rejects A2", 8'hA2, 1'b0); bus_stop();
    s0 = strobes;
    bus_start(); do_byte("R4 exact default accepts A0", 8'hA0, 1'b1); bus_stop();
    chk("R9 one strobe per match", strobes - s0, 32'd1);
    chk("R9 rnw write", {31'd0, rnw}, 32'd0);
  endtask

  task automatic t_worked();
    logic [7:0] list [9] = '{8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'hA2, 8'hA6, 8'hB0, 8'hE0, 8'hA5};
    logic [7:0] b;
    logic exp;
    int s0;
    cfg_write(2'd2, 8'h09);
    cfg_write(2'd0, 8'hF3);
    cfg_write(2'd2, 8'h06);
    for (int k = 0; k < 9; k++) begin
      b = list[k];
      exp = (((b ^ 8'hA0) & 8'hF2) == 8'h00);
      s0 = strobes;
      bus_start(); do_byte("R6 R3 masked 7-bit match", b, exp); bus_stop();
      chk("R9 strobe count", strobes - s0, {31'd0, exp});
    end
    chk("R6 rnw read on A5", {31'd0, rnw}, 32'd1);
  endtask

  task automatic t_routing();
    cfg_write(2'd0, 8'h30);  // mode 0110: address location holds the address
    bus_start(); do_byte("R5 address write kept mask", 8'h34, 1'b1); bus_stop();
    bus_start(); do_byte("R5 old address gone", 8'hA0, 1'b0); bus_stop();
    cfg_write(2'd2, 8'h00);
    bus_start(); do_byte("R5 mode 0000 no ack", 8'h30, 1'b0); bus_stop();
    cfg_write(2'd2, 8'h09);
    bus_start(); do_byte("R5 mode 1001 no ack", 8'h30, 1'b0); bus_stop();
  endtask

  task automatic t_ten_bit();
    int s0;
    cfg_write(2'd2, 8'h09);
    cfg_write(2'd0, 8'hF0);
    cfg_write(2'd2, 8'h07);
    cfg_write(2'd0, 8'h5C);
    cfg_write(2'd1, 8'h02);
    s0 = strobes;
    bus_start();
    do_byte("R7 header accepted", 8'hF4, 1'b1);
    chk("R9 no strobe after header", strobes - s0, 32'd0);
    do_byte("R7 masked low byte accepted", 8'h53, 1'b1);
    bus_stop();
    chk("R9 strobe after low byte", strobes - s0, 32'd1);
    chk("R9 rnw from header", {31'd0, rnw}, 32'd0);
    bus_start(); do_byte("R7 wrong upper bits", 8'hF2, 1'b0); bus_stop();
    bus_start(); do_byte("R7 plain byte in 10-bit mode", 8'h5C, 1'b0); bus_stop();
    s0 = strobes;
    bus_start();
    do_byte("R7 header again", 8'hF4, 1'b1);
    do_byte("R7 low byte mismatch", 8'h63, 1'b0);
    bus_stop();
    chk("R7 no strobe on low mismatch", strobes - s0, 32'd0);
  endtask

  task automatic t_abort();
    logic hi;
    int s0;
    cfg_write(2'd2, 8'h09);
    cfg_write(2'd0, 8'hFF);
    cfg_write(2'd2, 8'h06);
    cfg_write(2'd0, 8'hA0);
    s0 = strobes;
    bus_start(); send_bits(8'hA0, 4, hi); bus_stop();
    wait_c(HALF);
    chk("R2 stop mid byte no ack", {31'd0, sda_oe}, 32'd0);
    chk("R2 stop mid byte no strobe", strobes - s0, 32'd0);
    bus_start(); send_bits(8'hA0, 4, hi);
    bus_start();
    do_byte("R2 repeated start restarts", 8'hA0, 1'b1);
    bus_stop();
    chk("R2 one strobe after restart", strobes - s0, 32'd1);
  endtask

  task automatic t_ignore();
    bus_start();
    do_byte("R10 mismatch no ack", 8'hB0, 1'b0);
    do_byte("R10 ignored until START", 8'hA0, 1'b0);
    bus_stop();
    bus_start(); do_byte("R10 rearmed by START", 8'hA0, 1'b1); bus_stop();
  endtask

  initial begin
    wait_c(5);
    rst_n = 1'b1;
    wait_c(3);
    t_reset();
    t_default_exact();
    t_worked();
    t_routing();
    t_ten_bit();
    t_abort();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("TIMEOUT watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule